// File: doc/BRIEF.md
# Serial Peripheral Slave with Select-Framed Bytes

This block is the receiving end of a four-wire serial peripheral link. It runs from a fast system clock and samples the external serial clock, active-low select and master-out data lines through synchronisers. Each transfer moves exactly eight bits in both directions. The block shifts a byte supplied by local logic out on the slave-out line. The byte it receives is placed in a holding register, which stays unchanged until the next complete byte overwrites it.

Clock polarity, clock phase and bit order are static configuration inputs and must match the master. In phase mode 0 each byte is framed by its own select falling edge, and the first output bit is presented before any clock edge. In phase mode 1 the first clock edge starts the byte, and bytes may follow back to back while select stays low. The slave-out driver is enabled only while the slave is selected. The serial clock must run no faster than one quarter of the system clock.

Top module: `spi_frame_slave`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `miso_oe` is 0, `rx_valid` is 0 and `rx_data` is 0.
- R2: `miso_oe` is 1 only while the synchronised select is low, within three system cycles of a change on `ss_n`. While select is high, `miso_out` does not change.
- R3: With `cfg_cpha`=0, the first bit of `tx_data` appears on `miso_out` within three system cycles of the select falling edge, before any serial clock edge.
- R4: With `cfg_cpha`=0, `mosi` is captured on each leading edge (the edge leaving the idle level) and `miso_out` advances on each trailing edge.
- R5: With `cfg_cpha`=0, after eight bits, further serial clock edges are ignored while select stays low. No data is captured and `rx_valid` stays 0 until select has gone high and then low again.
- R6: With `cfg_cpha`=1, `miso_out` advances on each leading edge, with the first leading edge of a byte loading `tx_data`, and `mosi` is captured on each trailing edge. Several bytes may be sent while select stays low.
- R7: `cfg_cpol`=0 means the serial clock idles low and `cfg_cpol`=1 means it idles high. All four polarity and phase combinations transfer correctly.
- R8: `cfg_lsb_first`=0 sends and receives bit 7 first. `cfg_lsb_first`=1 sends and receives bit 0 first.
- R9: When the eighth bit is captured, `rx_data` takes the received byte and `rx_valid` is high for exactly one cycle. At all other times `rx_data` holds its value.
- R10: If select rises before eight bits are captured, the partial byte is discarded and `rx_valid` does not pulse. The next byte is received in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Phase mode: 0 = select-framed, 1 = clock-started |
| cfg_lsb_first | input | 1 | Bit order: 1 = bit 0 first |
| tx_data | input | 8 | Byte to return to the master |
| sck | input | 1 | Serial clock from the master (asynchronous) |
| ss_n | input | 1 | Active-low slave select (asynchronous) |
| mosi | input | 1 | Serial data from the master (asynchronous) |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the slave-out pad driver |
| rx_data | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
A bit counter that drifts, or a completed-frame flag that is not cleared, shows up at the ports within one byte. Either one makes `rx_data` shift by one position, makes `rx_valid` pulse early or late, or loses the next phase-mode-0 byte entirely. A wrongly loaded or oriented transmit shifter corrupts the very first sampled `miso_out` bit, three system cycles after the select edge or the first leading clock edge. The bench keeps a master model that checks both directions bit by bit in all four modes. It also counts `rx_valid` pulses, so a missing or extra completion is seen at the end of the frame.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_cfg_t;

  localparam int unsigned SYNC_W = 3;
  localparam int unsigned SYNC_SCK = 2;
  localparam int unsigned SYNC_SS = 1;
  localparam int unsigned SYNC_MOSI = 0;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stage_q[s] <= async_in;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic sck_s,
  input  logic ss_s,
  output logic lead,
  output logic trail,
  output logic ss_fall
);

  logic sck_q;
  logic ss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      ss_q  <= ss_s;
    end
  end

  always_comb begin
    lead    = (sck_s != sck_q) && (sck_s != cpol);
    trail   = (sck_s != sck_q) && (sck_s == cpol);
    ss_fall = ss_q && !ss_s;
  end

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_cfg_t          cfg,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ss_s,
  input  logic              mosi_s,
  input  logic              lead,
  input  logic              trail,
  input  logic              ss_fall,
  output logic              miso_out,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_done
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [DATA_W-1:0] tx_load;
  logic [DATA_W-1:0] rx_next;
  logic              done_q;
  logic              sample;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      tx_load[i] = cfg.lsb_first ? tx_data[DATA_W-1-i] : tx_data[i];
    end
    rx_next = cfg.lsb_first ? {mosi_s, rx_sh_q[DATA_W-1:1]}
                            : {rx_sh_q[DATA_W-2:0], mosi_s};
    sample  = cfg.cpha ? trail : lead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      done_q   <= 1'b0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      miso_oe  <= !ss_s;
      if (ss_s) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (ss_fall) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
        if (!cfg.cpha) tx_sh_q <= tx_load;
      end else if (!done_q) begin
        if (sample) begin
          rx_sh_q <= rx_next;
          if (cnt_q == LAST) begin
            cnt_q    <= '0;
            rx_data  <= rx_next;
            rx_valid <= 1'b1;
            done_q   <= !cfg.cpha;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (!cfg.cpha && trail) begin
          tx_sh_q <= tx_sh_q << 1;
        end
        if (cfg.cpha && lead) begin
          tx_sh_q <= (cnt_q == '0) ? tx_load : (tx_sh_q << 1);
        end
      end
    end
  end

  assign miso_out   = tx_sh_q[DATA_W-1];
  assign frame_done = done_q;

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso_out,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  spi_cfg_t            cfg;
  logic [SYNC_W-1:0]   pins_s;
  logic                ss_sync;
  logic                sck_sync;
  logic                mosi_sync;
  logic                lead;
  logic                trail;
  logic                ss_fall;
  logic                frame_done;

  assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

  spi_slv_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_W'(1) << SYNC_SS)
  ) u_sync (
    .clk(clk), .rst(rst),
    .async_in({sck, ss_n, mosi}),
    .sync_out(pins_s)
  );

  assign sck_sync  = pins_s[SYNC_SCK];
  assign ss_sync   = pins_s[SYNC_SS];
  assign mosi_sync = pins_s[SYNC_MOSI];

  spi_slv_edge u_edge (
    .clk(clk), .rst(rst), .cpol(cfg.cpol),
    .sck_s(sck_sync), .ss_s(ss_sync),
    .lead(lead), .trail(trail), .ss_fall(ss_fall)
  );

  spi_slv_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .cfg(cfg), .tx_data(tx_data),
    .ss_s(ss_sync), .mosi_s(mosi_sync),
    .lead(lead), .trail(trail), .ss_fall(ss_fall),
    .miso_out(miso_out), .miso_oe(miso_oe),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_done(frame_done)
  );

endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ss_sync,
  input logic              frame_done,
  input logic              miso_out,
  input logic              miso_oe,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!miso_oe && !rx_valid && rx_data == '0));

  p_idle_miso_r2: assert property (@(posedge clk) disable iff (rst)
    (ss_sync && $past(ss_sync)) |=> $stable(miso_out));

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !ss_sync) |=> !rx_valid);

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));

  p_no_done_deselected_r10: assert property (@(posedge clk) disable iff (rst)
    ss_sync |=> !rx_valid);

endmodule

bind spi_frame_slave spi_frame_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ss_sync(ss_sync), .frame_done(frame_done),
  .miso_out(miso_out), .miso_oe(miso_oe),
  .rx_data(rx_data), .rx_valid(rx_valid)
);

// File: tb/spi_frame_slave_bench.sv
`timescale 1ns/1ps
module spi_frame_slave_bench;

  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpol = 1'b0, cpha = 1'b0, lsbf = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso_out, miso_oe, rx_valid;
  logic [7:0] rx_data;

  int checks = 0;
  int fails  = 0;
  int vcnt   = 0;

  always #10 clk = ~clk;

  spi_frame_slave u_spi_frame_slave (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsbf), .tx_data(tx_data), .sck(sck), .ss_n(ss_n),
    .mosi(mosi), .miso_out(miso_out), .miso_oe(miso_oe),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(posedge clk) if (!rst && rx_valid) vcnt <= vcnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitpos(input int i, input logic lsb);
    return lsb ? i : 7 - i;
  endfunction

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic l);
    ss_n = 1'b1;
    wait_h();
    cpol = p; cpha = h; lsbf = l; sck = p;
    wait_h();
  endtask

  task automatic select();
    ss_n = 1'b0;
    wait_h();
  endtask

  task automatic deselect();
    ss_n = 1'b1;
    wait_h();
  endtask

  // Clocks nbits bits; returns the MISO bits seen, arranged as a byte.
  task automatic shift_bits(input logic [7:0] mval, input int nbits, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi = mval[bitpos(i, lsbf)];
        wait_h();
        got[bitpos(i, lsbf)] = miso_out;
        sck = ~cpol;
        wait_h();
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mval[bitpos(i, lsbf)];
        wait_h();
        got[bitpos(i, lsbf)] = miso_out;
        sck = cpol;
        wait_h();
      end
    end
    wait_h();
  endtask

  task automatic full_byte(input logic [7:0] tx, input logic [7:0] mv, input string req);
    logic [7:0] got;
    int v0;
    v0 = vcnt;
    tx_data = tx;
    if (!cpha) select();
    shift_bits(mv, 8, got);
    check(got == tx, req, got, tx);
    check(rx_data == mv, req, rx_data, mv);
    check(vcnt == v0 + 1, "R9", vcnt - v0, 1);
    if (!cpha) deselect();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] held;
    int v0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check(miso_oe == 1'b0 && rx_valid == 1'b0 && rx_data == 8'h00, "R1",
          {miso_oe, rx_valid, rx_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(miso_oe == 1'b0 && rx_valid == 1'b0 && rx_data == 8'h00, "R1",
          {miso_oe, rx_valid, rx_data}, 0);

    // R2: enable follows select
    set_mode(1'b0, 1'b0, 1'b0);
    check(miso_oe == 1'b0, "R2", miso_oe, 0);
    tx_data = 8'hA5;
    select();
    check(miso_oe == 1'b1, "R2", miso_oe, 1);
    // R3: first bit ready before any clock edge
    check(miso_out == 1'b1, "R3", miso_out, 1);
    deselect();
    check(miso_oe == 1'b0, "R2", miso_oe, 0);
    held = {7'b0, miso_out};
    sck = 1'b1; wait_h(); sck = 1'b0; wait_h();
    check(miso_out == held[0], "R2", miso_out, held[0]);

    // R4, R8: mode 0, both bit orders
    full_byte(8'h3C, 8'hC6, "R4");
    set_mode(1'b0, 1'b0, 1'b1);
    tx_data = 8'h01;
    select();
    check(miso_out == 1'b1, "R8", miso_out, 1);
    deselect();
    full_byte(8'h96, 8'h1E, "R8");

    // R5: extra clocks after 8 bits are ignored
    set_mode(1'b1, 1'b0, 1'b0);
    tx_data = 8'h5A;
    select();
    shift_bits(8'h81, 8, got);
    check(rx_data == 8'h81, "R5", rx_data, 8'h81);
    v0 = vcnt;
    shift_bits(8'h7E, 8, got);
    check(vcnt == v0 && rx_data == 8'h81, "R5", rx_data, 8'h81);
    deselect();
    full_byte(8'hE7, 8'h42, "R5");

    // R6: mode 1, back to back bytes under one select
    set_mode(1'b0, 1'b1, 1'b0);
    select();
    full_byte(8'hB4, 8'h2D, "R6");
    full_byte(8'h0F, 8'hF0, "R6");
    deselect();

    // R10: abort mid byte
    set_mode(1'b1, 1'b1, 1'b1);
    select();
    v0 = vcnt;
    held = rx_data;
    tx_data = 8'h33;
    shift_bits(8'hFF, 4, got);
    deselect();
    check(vcnt == v0 && rx_data == held, "R10", rx_data, held);
    select();
    full_byte(8'h6C, 8'h93, "R10");
    deselect();
    set_mode(1'b0, 1'b0, 1'b0);
    select();
    v0 = vcnt;
    shift_bits(8'h00, 3, got);
    deselect();
    check(vcnt == v0, "R10", vcnt - v0, 0);
    full_byte(8'hC3, 8'h5B, "R10");

    // R7: random traffic across all four modes
    for (int n = 0; n < 24; n++) begin
      logic [2:0] m;
      int nb;
      m = 3'($urandom);
      set_mode(m[0], m[1], m[2]);
      if (m[1]) begin
        nb = 1 + ($urandom % 3);
        select();
        for (int b = 0; b < nb; b++) full_byte(8'($urandom), 8'($urandom), "R7");
        deselect();
      end else begin
        full_byte(8'($urandom), 8'($urandom), "R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule